// File: doc/BRIEF.md
# I2C Master Byte Receiver with Eighth-Clock Stall

This block is the receive side of an I2C master. A host on a small register bus opens a bus transaction, starts reading bytes from a slave, picks the acknowledge level for each byte, and closes the transaction with a stop condition. The block drives SCL and SDA as open-drain lines (an output enable of 1 pulls the line low) and watches both lines through separate inputs. Each high and low phase of SCL lasts `HALF_CYC` system clocks. A high phase only begins counting once SCL reads high, so a slave that holds the clock low simply lengthens that phase.

Two notification modes exist. With the stall mode off, the flag rises once per byte, on the rising SCL edge of the acknowledge clock. With the stall mode on, the flag also rises when SCL falls after the eighth data bit. SCL is then held low, so the host can read the byte and choose ACK or NACK before the ninth clock. Clearing the flag releases the clock. After each acknowledge clock, the next byte starts only once the flag is clear and the direction bit still selects receive. Setting the direction bit to transmit parks the bus with SCL low, and a stop command may then be issued.

The controller has these states: `S_IDLE`, `S_STA_SDA`, `S_STA_SCL`, `S_READY`, `S_BIT_LO`, `S_BIT_HI`, `S_WAIT8`, `S_ACK_LO`, `S_ACK_HI`, `S_HOLD`, `S_STO_SDA`, `S_STO_SCL` and `S_STO_END`. Its transitions are:
- IDLE to STA_SDA on a start command.
- STA_SDA to STA_SCL, STA_SCL to READY, BIT_LO to BIT_HI, ACK_LO to ACK_HI and ACK_HI to HOLD, each when a phase ends.
- READY to BIT_LO on a data read while in receive direction.
- READY to STO_SDA on a stop command.
- BIT_HI to BIT_LO after bits 1 to 7.
- BIT_HI to WAIT8 after bit 8 in stall mode, or to ACK_LO without stall mode.
- WAIT8 to ACK_LO when the flag is clear.
- HOLD to READY when the direction is transmit.
- HOLD to BIT_LO when the flag is clear and the direction is receive.
- STO_SDA to STO_SCL to STO_END to IDLE, each when a phase ends.

Top module: `i2c_mrx_seq`

Register map:
- CTRL, address 0:
  - bit0: direction, 1 = transmit/park.
  - bit1: ack level.
  - bit2: stall enable.
  - bit3: busy (reads bus activity).
  - bit4: start/stop control.
- STAT, address 1:
  - bit0: flag.
  - bit1: byte-done.
- DATA, address 2: received byte (read only).

## Requirements
- R1: After reset both lines are released. CTRL bit3 (busy) reads 0, STAT reads 0 and DATA reads 0.
- R2: Writing CTRL with bit3=1 and bit4=1 while idle drives SDA low while SCL is high, then pulls SCL low. CTRL bit3 reads 1 from then on.
- R3: A read of DATA while parked, with CTRL bit0=0, starts one byte of eight SCL clocks. SDA is sampled on each rising SCL edge, MSB first, and DATA holds the byte after the eighth bit.
- R4: With CTRL bit2=1, STAT bit0 rises and STAT bit1 reads 0 when SCL falls after the eighth bit. SCL then stays low with no further clocks while STAT bit0 is 1.
- R5: Clearing STAT bit0 (writing STAT with bit0=0) in the stall releases SCL for the acknowledge clock within HALF_CYC+2 clocks.
- R6: On the ninth clock SDA is pulled low when CTRL bit1=0 (ACK) and released when CTRL bit1=1 (NACK). The level is captured when that clock's low phase begins.
- R7: In both modes STAT bit0 rises with STAT bit1=1 on the rising SCL edge of the ninth clock. With CTRL bit2=0 the flag does not rise earlier in the byte.
- R8: After the ninth clock SCL stays low. The next byte starts only when STAT bit0 is 0 and CTRL bit0 is 0. With CTRL bit0=1 no further clocks occur, even after the flag is cleared.
- R9: Writing CTRL with bit3=0 and bit4=0 while parked gives a stop in this order: SDA low with SCL low, SCL released, then SDA released while SCL is high. CTRL bit3 stays 1 until that ends and reads 0 afterwards.
- R10: Writing STAT with bit0=1 leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effect on DATA) |
| host_addr | input | 2 | Register select |
| host_wdata | input | 5 | Write data |
| host_rdata | output | BYTE_W | Read data for host_addr |
| scl_i | input | 1 | Sensed SCL level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_i | input | 1 | Sensed SDA level |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A controller stuck in the wrong state shows up as a wrong bus shape. Examples are a clock edge counted into the ninth clock before the flag was cleared, or an acknowledge level that flips during the high phase. A bus monitor catches these within one SCL period, because it rebuilds every byte and acknowledge from the lines. A wrong bit count or a misplaced data copy shows up as a mismatch on the next DATA read, or on the monitor's byte check, at the end of that byte. Flag bookkeeping errors appear as a missing or early STAT bit0. The bench measures that in rising SCL edges since the byte began, so an error is caught at the eighth or ninth clock.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_STA_SDA,
        S_STA_SCL,
        S_READY,
        S_BIT_LO,
        S_BIT_HI,
        S_WAIT8,
        S_ACK_LO,
        S_ACK_HI,
        S_HOLD,
        S_STO_SDA,
        S_STO_SCL,
        S_STO_END
    } rx_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_STAT = 2'd1;
    localparam logic [1:0] REG_DATA = 2'd2;

    localparam int C_DIR   = 0;
    localparam int C_ACK   = 1;
    localparam int C_STALL = 2;
    localparam int C_BUSY  = 3;
    localparam int C_SS    = 4;

    localparam int F_FLAG  = 0;

endpackage

// File: rtl/i2cr_phase_timer.sv
module i2cr_phase_timer #(
    parameter int HALF_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic first,
    output logic expire
);
    localparam int CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign first  = (cnt_q == '0);
    assign expire = (cnt_q == LAST);

endmodule

// File: rtl/i2cr_rx_shift.sv
module i2cr_rx_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] value,
    output logic              full
);
    localparam int NW = $clog2(BYTE_W + 1);
    localparam logic [NW-1:0] NBITS = NW'(BYTE_W);

    logic [BYTE_W-1:0] sr_q;
    logic [NW-1:0]     num_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            num_q <= '0;
        end else if (clr) begin
            num_q <= '0;
        end else if (shift_en) begin
            sr_q  <= {sr_q[BYTE_W-2:0], bit_in};
            num_q <= num_q + 1'b1;
        end
    end

    assign value = sr_q;
    assign full  = (num_q == NBITS);

    // R3: never more than one byte of bits per byte start
    a_r3_no_overshift: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !shift_en);

endmodule

// File: rtl/i2cr_host_regs.sv
module i2cr_host_regs
    import i2cr_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_addr,
    input  logic [4:0]        host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              busy,
    input  logic              set_wait,
    input  logic              set_done,
    input  logic              load_byte,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              dir_tx,
    output logic              ack_lvl,
    output logic              stall_en,
    output logic              irq,
    output logic              rx_done,
    output logic              start_req,
    output logic              stop_req,
    output logic              data_rd
);
    logic              ss_q;
    logic [BYTE_W-1:0] data_q;
    logic              wr_ctrl;
    logic              clr_flag;

    assign wr_ctrl   = host_wr && (host_addr == REG_CTRL);
    assign clr_flag  = host_wr && (host_addr == REG_STAT) && !host_wdata[F_FLAG];
    assign start_req = wr_ctrl && host_wdata[C_BUSY] && host_wdata[C_SS];
    assign stop_req  = wr_ctrl && !host_wdata[C_BUSY] && !host_wdata[C_SS];
    assign data_rd   = host_rd && (host_addr == REG_DATA);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_tx   <= 1'b0;
            ack_lvl  <= 1'b0;
            stall_en <= 1'b0;
            ss_q     <= 1'b0;
        end else if (wr_ctrl) begin
            dir_tx   <= host_wdata[C_DIR];
            ack_lvl  <= host_wdata[C_ACK];
            stall_en <= host_wdata[C_STALL];
            ss_q     <= host_wdata[C_SS];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq     <= 1'b0;
            rx_done <= 1'b0;
        end else begin
            if (set_wait || set_done) begin
                irq <= 1'b1;
            end else if (clr_flag) begin
                irq <= 1'b0;
            end
            if (set_wait) begin
                rx_done <= 1'b0;
            end else if (set_done) begin
                rx_done <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_byte) begin
            data_q <= rx_byte;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            REG_CTRL: host_rdata = BYTE_W'({ss_q, busy, stall_en, ack_lvl, dir_tx});
            REG_STAT: host_rdata = BYTE_W'({rx_done, irq});
            REG_DATA: host_rdata = data_q;
            default:  host_rdata = '0;
        endcase
    end

    // R10: a write of 1 to the flag bit never raises the flag by itself
    a_r10_flag_write_one: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == REG_STAT && host_wdata[F_FLAG] && !irq
         && !set_wait && !set_done) |=> !irq);

    // R7: byte-done never appears without the flag
    a_r7_done_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_done) |-> irq);

endmodule

// File: rtl/i2c_mrx_seq.sv
module i2c_mrx_seq
    import i2cr_pkg::*;
#(
    parameter int HALF_CYC = 8,   // clocks per SCL half period, at least 2
    parameter int BYTE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [1:0]        host_addr,
    input  logic [4:0]        host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              scl_i,
    output logic              scl_oe,
    input  logic              sda_i,
    output logic              sda_oe
);
    rx_state_e state_q, state_d;

    logic              dir_tx, ack_lvl, stall_en, irq, rx_done;
    logic              start_req, stop_req, data_rd;
    logic              tmr_clr, tmr_first, tmr_exp;
    logic              hi_ph, sample, shift_en, byte_start, byte_end;
    logic              set_wait, set_done;
    logic              rx_full;
    logic [BYTE_W-1:0] rx_value;
    logic              ack_drv;
    logic              busy;

    assign busy       = (state_q != S_IDLE);
    assign hi_ph      = (state_q == S_BIT_HI) || (state_q == S_ACK_HI);
    assign tmr_clr    = (state_d != state_q) || (hi_ph && !scl_i);
    assign sample     = hi_ph && tmr_first && scl_i;
    assign shift_en   = sample && (state_q == S_BIT_HI);
    assign byte_start = (state_q == S_READY || state_q == S_HOLD) && (state_d == S_BIT_LO);
    assign byte_end   = (state_q == S_BIT_HI) && tmr_exp && rx_full;
    assign set_wait   = byte_end && stall_en;
    assign set_done   = sample && (state_q == S_ACK_HI);

    i2cr_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .first  (tmr_first),
        .expire (tmr_exp)
    );

    i2cr_rx_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (byte_start),
        .shift_en (shift_en),
        .bit_in   (sda_i),
        .value    (rx_value),
        .full     (rx_full)
    );

    i2cr_host_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .set_wait   (set_wait),
        .set_done   (set_done),
        .load_byte  (byte_end),
        .rx_byte    (rx_value),
        .dir_tx     (dir_tx),
        .ack_lvl    (ack_lvl),
        .stall_en   (stall_en),
        .irq        (irq),
        .rx_done    (rx_done),
        .start_req  (start_req),
        .stop_req   (stop_req),
        .data_rd    (data_rd)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start_req) state_d = S_STA_SDA;
            S_STA_SDA: if (tmr_exp) state_d = S_STA_SCL;
            S_STA_SCL: if (tmr_exp) state_d = S_READY;
            S_READY: begin
                if (stop_req) begin
                    state_d = S_STO_SDA;
                end else if (data_rd && !dir_tx) begin
                    state_d = S_BIT_LO;
                end
            end
            S_BIT_LO:  if (tmr_exp) state_d = S_BIT_HI;
            S_BIT_HI: begin
                if (tmr_exp) begin
                    if (!rx_full) begin
                        state_d = S_BIT_LO;
                    end else if (stall_en) begin
                        state_d = S_WAIT8;
                    end else begin
                        state_d = S_ACK_LO;
                    end
                end
            end
            S_WAIT8:   if (!irq) state_d = S_ACK_LO;
            S_ACK_LO:  if (tmr_exp) state_d = S_ACK_HI;
            S_ACK_HI:  if (tmr_exp) state_d = S_HOLD;
            S_HOLD: begin
                if (dir_tx) begin
                    state_d = S_READY;
                end else if (!irq) begin
                    state_d = S_BIT_LO;
                end
            end
            S_STO_SDA: if (tmr_exp) state_d = S_STO_SCL;
            S_STO_SCL: if (tmr_exp) state_d = S_STO_END;
            S_STO_END: if (tmr_exp) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // acknowledge level captured as the ninth clock's low phase begins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_drv <= 1'b0;
        end else if (state_d == S_ACK_LO && state_q != S_ACK_LO) begin
            ack_drv <= !ack_lvl;
        end
    end

    // line outputs
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state_q)
            S_IDLE:    begin scl_oe = 1'b0; sda_oe = 1'b0;    end
            S_STA_SDA: begin scl_oe = 1'b0; sda_oe = 1'b1;    end
            S_STA_SCL: begin scl_oe = 1'b1; sda_oe = 1'b1;    end
            S_READY:   begin scl_oe = 1'b1; sda_oe = 1'b0;    end
            S_BIT_LO:  begin scl_oe = 1'b1; sda_oe = 1'b0;    end
            S_BIT_HI:  begin scl_oe = 1'b0; sda_oe = 1'b0;    end
            S_WAIT8:   begin scl_oe = 1'b1; sda_oe = 1'b0;    end
            S_ACK_LO:  begin scl_oe = 1'b1; sda_oe = ack_drv; end
            S_ACK_HI:  begin scl_oe = 1'b0; sda_oe = ack_drv; end
            S_HOLD:    begin scl_oe = 1'b1; sda_oe = ack_drv; end
            S_STO_SDA: begin scl_oe = 1'b1; sda_oe = 1'b1;    end
            S_STO_SCL: begin scl_oe = 1'b0; sda_oe = 1'b1;    end
            S_STO_END: begin scl_oe = 1'b0; sda_oe = 1'b0;    end
            default:   begin scl_oe = 1'b0; sda_oe = 1'b0;    end
        endcase
    end

    // R4: entering the stall raises the flag, marks a wait point, holds SCL low
    a_r4_stall_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && stall_en) |=> (irq && !rx_done && scl_oe));

    // R4: SCL stays low while a wait-point flag is pending
    a_r4_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_oe && irq && !rx_done && state_q == S_WAIT8) |=> scl_oe);

    // R5: a cleared flag in the stall moves on to the acknowledge clock
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT8 && !irq) |=> (state_q == S_ACK_LO));

    // R2: SDA only falls with SCL released when a start is being made
    a_r2_start_shape: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe) |-> (state_q == S_STA_SDA));

    // R9: SDA only rises with SCL released at the end of a stop
    a_r9_stop_shape: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe) |-> (state_q == S_STO_END));

    // R6: acknowledge level does not move while SCL is high
    a_r6_ack_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ACK_HI && $past(state_q) == S_ACK_HI) |-> $stable(sda_oe));

endmodule

// File: tb/test_i2c_mrx_seq.sv
module test_i2c_mrx_seq;

    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [4:0] host_wdata = 5'd0;
    logic [7:0] host_rdata;
    logic       scl_oe, sda_oe;
    logic       scl_line, sda_line;
    logic       slave_pull;

    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | slave_pull);

    i2c_mrx_seq #(.HALF_CYC(HALF), .BYTE_W(8)) i_i2c_mrx_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .scl_i      (scl_line),
        .scl_oe     (scl_oe),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard: {ack, byte} expected on the bus; slave bytes to send
    logic [8:0] exp_q[$];
    logic [7:0] slv_q[$];

    task automatic expect_byte(input logic [7:0] b, input logic ack);
        exp_q.push_back({ack, b});
        slv_q.push_back(b);
    endtask

    // bus monitor and slave model, all sampled away from the active edge
    int         rises = 0, starts = 0, stops = 0, bpos = 0, sidx = 0;
    logic       p_scl = 1'b1, p_sda = 1'b1;
    logic [7:0] sh = 8'h00, sbyte = 8'hFF;
    logic       sfirst = 1'b0, s_act = 1'b0, s_nack = 1'b0;

    always_comb begin
        slave_pull = 1'b0;
        if (s_act && sidx < 8) slave_pull = !sbyte[7-sidx];
    end

    always @(negedge clk) begin
        if (p_sda && !sda_line && p_scl && scl_line) begin
            starts++;
            bpos   = 0;
            s_act  = 1'b1;
            sfirst = 1'b1;
            sidx   = 0;
            sbyte  = (slv_q.size() > 0) ? slv_q.pop_front() : 8'hFF;
        end
        if (!p_sda && sda_line && p_scl && scl_line) begin
            stops++;
            s_act = 1'b0;
        end
        if (!p_scl && scl_line) begin
            rises++;
            if (bpos < 8) begin
                sh   = {sh[6:0], sda_line};
                bpos = bpos + 1;
            end else begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected byte on bus", sh, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk(sh == e[7:0], "R3 byte seen on bus", sh, e[7:0]);
                    chk(sda_line == e[8], "R6 ack level on ninth clock", sda_line, e[8]);
                end
                s_nack = sda_line;
                bpos   = 0;
            end
        end
        if (p_scl && !scl_line && s_act) begin
            if (sfirst) begin
                sfirst = 1'b0;
            end else if (sidx == 8) begin
                sidx = 0;
                if (s_nack) s_act = 1'b0;
                sbyte = (slv_q.size() > 0) ? slv_q.pop_front() : 8'hFF;
            end else begin
                sidx = sidx + 1;
            end
        end
        p_scl = scl_line;
        p_sda = sda_line;
    end

    task automatic reg_wr(input logic [1:0] a, input logic [4:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wait_flag(input string req, output logic [7:0] st);
        bit seen = 1'b0;
        for (int i = 0; i < 3000 && !seen; i++) begin
            reg_rd(2'd1, st);
            seen = st[0];
        end
        chk(seen, req, 0, 1);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int r0;
        bit hi_seen;

        wait_cycles(5);
        rst_n = 1'b1;
        wait_cycles(2);

        // R1: reset state
        reg_rd(2'd0, v); chk(v[3] == 1'b0, "R1 busy after reset", v[3], 0);
        reg_rd(2'd1, v); chk(v == 8'h00, "R1 status after reset", v, 0);
        reg_rd(2'd2, v); chk(v == 8'h00, "R1 data after reset", v, 0);
        chk(scl_line && sda_line, "R1 lines released", {scl_line, sda_line}, 3);

        expect_byte(8'hA5, 1'b0);
        expect_byte(8'h3C, 1'b0);
        expect_byte(8'h81, 1'b1);

        // R2: start, stall mode on, ACK, receive direction
        reg_wr(2'd0, 5'h1C);
        wait_cycles(2 * HALF + 4);
        chk(starts == 1, "R2 start condition seen", starts, 1);
        chk(scl_line == 1'b0, "R2 SCL held low after start", scl_line, 0);
        reg_rd(2'd0, v); chk(v[3] == 1'b1, "R2 busy after start", v[3], 1);

        // R3/R4: dummy read starts byte 1, stall at eighth clock
        r0 = rises;
        reg_rd(2'd2, v);
        wait_flag("R4 flag at eighth clock", v);
        chk(v[1] == 1'b0, "R4 byte-done clear at wait point", v[1], 0);
        chk(rises - r0 == 8, "R4 eight clocks before stall", rises - r0, 8);
        reg_rd(2'd2, v); chk(v == 8'hA5, "R3 data byte 1", v, 8'hA5);
        wait_cycles(20);
        chk(scl_line == 1'b0 && rises - r0 == 8, "R4 SCL held in stall", rises - r0, 8);

        // R10: writing 1 to flag changes nothing
        reg_wr(2'd1, 5'h01);
        wait_cycles(3);
        reg_rd(2'd1, v); chk(v[0] == 1'b1, "R10 flag kept on write of 1", v[0], 1);
        chk(rises - r0 == 8, "R10 no clock after write of 1", rises - r0, 8);

        // R5: clear releases SCL
        reg_wr(2'd1, 5'h00);
        hi_seen = 1'b0;
        for (int i = 0; i < HALF + 3 && !hi_seen; i++) begin
            @(negedge clk);
            hi_seen = scl_line;
        end
        chk(hi_seen, "R5 SCL released after clear", hi_seen, 1);

        // R7: flag with byte-done at ninth rising edge
        wait_flag("R7 flag at ninth clock", v);
        chk(v[1] == 1'b1, "R7 byte-done at ninth clock", v[1], 1);
        chk(rises - r0 == 9, "R7 nine clocks in byte 1", rises - r0, 9);

        // R8: pending flag blocks the next byte
        wait_cycles(30);
        chk(scl_line == 1'b0 && rises - r0 == 9, "R8 no clocks while flag set", rises - r0, 9);

        // byte 2 in stall mode
        r0 = rises;
        reg_wr(2'd1, 5'h00);
        wait_flag("R4 flag at eighth clock byte 2", v);
        chk(v[1] == 1'b0 && rises - r0 == 8, "R4 wait point byte 2", rises - r0, 8);
        reg_rd(2'd2, v); chk(v == 8'h3C, "R3 data byte 2", v, 8'h3C);
        reg_wr(2'd1, 5'h00);
        wait_flag("R7 flag at ninth clock byte 2", v);
        chk(v[1] == 1'b1, "R7 byte-done byte 2", v[1], 1);

        // byte 3: stall off, NACK, then transmit direction to park
        reg_wr(2'd0, 5'h1A);
        r0 = rises;
        reg_wr(2'd1, 5'h00);
        reg_wr(2'd0, 5'h1B);
        wait_flag("R7 flag in non-stall byte", v);
        chk(rises - r0 == 9, "R7 no flag before ninth clock", rises - r0, 9);
        chk(v[1] == 1'b1, "R7 byte-done non-stall", v[1], 1);
        reg_rd(2'd2, v); chk(v == 8'h81, "R3 data byte 3", v, 8'h81);

        // R8: parked, no clocks even after flag clear
        wait_cycles(30);
        reg_wr(2'd1, 5'h00);
        wait_cycles(30);
        chk(scl_line == 1'b0 && rises - r0 == 9, "R8 parked after final byte", rises - r0, 9);
        reg_rd(2'd2, v); chk(v == 8'h81, "R8 final read starts nothing", v, 8'h81);
        wait_cycles(20);
        chk(rises - r0 == 9, "R8 no clocks after final read", rises - r0, 9);

        // R9: stop
        reg_wr(2'd0, 5'h00);
        reg_rd(2'd0, v); chk(v[3] == 1'b1, "R9 busy during stop", v[3], 1);
        wait_cycles(3 * HALF + 4);
        chk(stops == 1, "R9 stop condition seen", stops, 1);
        reg_rd(2'd0, v); chk(v[3] == 1'b0, "R9 busy clear after stop", v[3], 0);
        chk(scl_line && sda_line, "R9 lines released after stop", {scl_line, sda_line}, 3);
        chk(exp_q.size() == 0, "R3 all expected bytes seen", exp_q.size(), 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule